// File: doc/BRIEF.md
# Background Signed Divider with Interlocked Quotient and Remainder Registers

This unit divides one 32-bit two's-complement value by another, over several cycles, while the issuing pipeline keeps going. A divide is started by a 16-bit packed instruction word together with the two operand values that the register file has already supplied. The unit also reports the two 3-bit register selectors it decoded from that word, so the register file can be addressed from them.

The quotient, truncated toward zero, goes to the LO result register. The remainder, which carries the sign of the dividend, goes to the HI result register. A read port returns either register. A read requested while a divide is in flight raises a stall until both registers hold the new result.

The iteration count depends on the data: only the quotient bit positions that the operand magnitudes leave open are computed. No input raises an error or a flag. A zero divisor and the one overflowing pair both yield defined values.

Top module: `sdiv_hilo`

## Requirements
- R1: A divide starts only when `issue_i` is high and `instr_i[15:11]` = 11101 and `instr_i[4:0]` = 11010. Any other word, or a valid word with `issue_i` low, leaves LO, HI and the stall behaviour unchanged.
- R2: `src_a_idx_o` equals `instr_i[10:8]` (dividend selector) and `src_b_idx_o` equals `instr_i[7:5]` (divisor selector) at all times.
- R3: LO receives the signed quotient `op_a_i / op_b_i`, truncated toward zero.
- R4: HI receives the remainder. It is zero or has the sign of the dividend, so that dividend = quotient × divisor + remainder.
- R5: A zero divisor gives LO = 0xFFFFFFFF and HI = dividend. The divide still completes and releases the stall.
- R6: 0x80000000 divided by 0xFFFFFFFF gives LO = 0x80000000 and HI = 0, with no other effect.
- R7: `rd_sel_i` = 0 selects LO and 1 selects HI on `rd_data_o`. `stall_o` is high exactly when `rd_req_i` is high and a divide is in flight.
- R8: A read in the same cycle as an accepted issue is not stalled and returns the value from before that divide.
- R9: Let n = max(0, sig|a| − sig|b| + 1), where sig is the index of the highest set bit plus one; n is 0 for a zero divisor. The divide is in flight for exactly n + 2 cycles after its issue cycle, so it takes at most 34.
- R10: LO and HI reset to zero and change only when a divide finishes. A divide issued while another is in flight abandons the old one, and the new result is written n + 2 cycles after the new issue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| issue_i | input | 1 | Instruction word valid this cycle |
| instr_i | input | 16 | Packed instruction word |
| op_a_i | input | 32 | Dividend value |
| op_b_i | input | 32 | Divisor value |
| src_a_idx_o | output | 3 | Decoded dividend register selector |
| src_b_idx_o | output | 3 | Decoded divisor register selector |
| rd_req_i | input | 1 | Read request for HI or LO |
| rd_sel_i | input | 1 | 0 = LO, 1 = HI |
| rd_data_o | output | 32 | Selected result register |
| stall_o | output | 1 | Read must wait, divide in flight |

## Verification
Two pairs of events can land in the same cycle. The first pair is a read request and a new issue. The bench drives both on the same edge and expects no stall and the old LO value. The second pair is a read request and the finishing write. The bench holds the read request from the issue cycle onward and counts the stalled cycles against n + 2. It expects the first unstalled sample to show the freshly written value. A restart in the middle of a divide is judged the same way: the old LO must stay visible, and the latency count starts again from the second issue.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_SETUP, ST_ITER, ST_FIN} div_st_e;
  localparam logic [4:0] OP_MAJOR = 5'b11101;
  localparam logic [4:0] OP_MINOR = 5'b11010;
endpackage

// File: rtl/sdiv_decode.sv
module sdiv_decode #(
  parameter int unsigned IW   = 16,
  parameter int unsigned IDXW = 3
) (
  input  logic            valid_i,
  input  logic [IW-1:0]   instr_i,
  output logic            go_o,
  output logic [IDXW-1:0] idx_a_o,
  output logic [IDXW-1:0] idx_b_o
);
  import sdiv_pkg::*;
  localparam int unsigned FW = 5;

  assign go_o    = valid_i && (instr_i[IW-1 -: FW] == OP_MAJOR) && (instr_i[FW-1:0] == OP_MINOR);
  assign idx_a_o = instr_i[IW-FW-1 -: IDXW];
  assign idx_b_o = instr_i[IW-FW-IDXW-1 -: IDXW];
endmodule

// File: rtl/sdiv_core.sv
module sdiv_core #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] q_o,
  output logic [W-1:0] r_o
);
  import sdiv_pkg::*;
  localparam int unsigned CW = $clog2(W + 2);

  function automatic logic [CW-1:0] sig_bits(input logic [W-1:0] x);
    sig_bits = '0;
    for (int i = 0; i < W; i++) if (x[i]) sig_bits = CW'(i + 1);
  endfunction

  div_st_e       st_q;
  logic [W-1:0]  rem_q, dvs_q, quo_q, a_hold_q;
  logic [CW-1:0] cnt_q;
  logic          neg_q_q, neg_r_q, dz_q;

  logic [W-1:0]  a_mag, b_mag;
  logic [CW-1:0] sa, sb, shamt, n_iter;

  assign a_mag  = a_i[W-1] ? (~a_i + 1'b1) : a_i;
  assign b_mag  = b_i[W-1] ? (~b_i + 1'b1) : b_i;
  assign sa     = sig_bits(rem_q);
  assign sb     = sig_bits(dvs_q);
  assign shamt  = sa - sb;
  assign n_iter = (sa >= sb) ? (shamt + 1'b1) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      rem_q    <= '0;
      dvs_q    <= '0;
      quo_q    <= '0;
      a_hold_q <= '0;
      cnt_q    <= '0;
      neg_q_q  <= 1'b0;
      neg_r_q  <= 1'b0;
      dz_q     <= 1'b0;
    end else if (start_i) begin
      // a new command always wins, abandoning any divide in flight
      st_q     <= ST_SETUP;
      rem_q    <= a_mag;
      dvs_q    <= b_mag;
      quo_q    <= '0;
      a_hold_q <= a_i;
      neg_q_q  <= a_i[W-1] ^ b_i[W-1];
      neg_r_q  <= a_i[W-1];
      dz_q     <= (b_i == '0);
    end else begin
      unique case (st_q)
        ST_SETUP: begin
          if (dz_q) begin
            st_q <= ST_FIN;
          end else begin
            // align divisor MSB with dividend MSB; skip leading quotient zeros
            dvs_q <= dvs_q << shamt;
            cnt_q <= n_iter;
            st_q  <= (n_iter == '0) ? ST_FIN : ST_ITER;
          end
        end
        ST_ITER: begin
          if (rem_q >= dvs_q) begin
            rem_q <= rem_q - dvs_q;
            quo_q <= {quo_q[W-2:0], 1'b1};
          end else begin
            quo_q <= {quo_q[W-2:0], 1'b0};
          end
          dvs_q <= dvs_q >> 1;
          cnt_q <= cnt_q - 1'b1;
          if (cnt_q == CW'(1)) st_q <= ST_FIN;
        end
        ST_FIN:  st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = (st_q != ST_IDLE);
  assign done_o = (st_q == ST_FIN) && !start_i;
  assign q_o    = dz_q ? '1 : (neg_q_q ? (~quo_q + 1'b1) : quo_q);
  assign r_o    = dz_q ? a_hold_q : (neg_r_q ? (~rem_q + 1'b1) : rem_q);
endmodule

// File: rtl/sdiv_hilo.sv
module sdiv_hilo #(
  parameter int unsigned W    = 32,
  parameter int unsigned IW   = 16,
  parameter int unsigned IDXW = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            issue_i,
  input  logic [IW-1:0]   instr_i,
  input  logic [W-1:0]    op_a_i,
  input  logic [W-1:0]    op_b_i,
  output logic [IDXW-1:0] src_a_idx_o,
  output logic [IDXW-1:0] src_b_idx_o,
  input  logic            rd_req_i,
  input  logic            rd_sel_i,
  output logic [W-1:0]    rd_data_o,
  output logic            stall_o
);
  logic         cmd_go, core_busy, core_done;
  logic [W-1:0] core_q, core_r, lo_q, hi_q;

  sdiv_decode #(.IW(IW), .IDXW(IDXW)) u_dec (
    .valid_i (issue_i),
    .instr_i (instr_i),
    .go_o    (cmd_go),
    .idx_a_o (src_a_idx_o),
    .idx_b_o (src_b_idx_o)
  );

  sdiv_core #(.W(W)) u_core (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (cmd_go),
    .a_i     (op_a_i),
    .b_i     (op_b_i),
    .busy_o  (core_busy),
    .done_o  (core_done),
    .q_o     (core_q),
    .r_o     (core_r)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (core_done) begin
      lo_q <= core_q;
      hi_q <= core_r;
    end
  end

  assign rd_data_o = rd_sel_i ? hi_q : lo_q;
  assign stall_o   = rd_req_i && core_busy;
endmodule

// File: rtl/sdiv_hilo_chk.sv
module sdiv_hilo_chk #(
  parameter int unsigned W = 32
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         start_i,
  input logic         busy_i,
  input logic         done_i,
  input logic         rd_req_i,
  input logic         stall_i,
  input logic [W-1:0] lo_i,
  input logic [W-1:0] hi_i
);
  localparam int unsigned MAXL = W + 2;
  logic [7:0] lat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      lat_q <= '0;
    else if (start_i) lat_q <= 8'd1;
    else if (busy_i)  lat_q <= lat_q + 8'd1;
    else              lat_q <= '0;
  end

  AST_START_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> busy_i); // R1

  AST_LATENCY_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> (lat_q <= 8'(MAXL))); // R9

  AST_DONE_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !busy_i); // R5

  AST_NO_STALL_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_i || !rd_req_i) |-> !stall_i); // R7

  AST_HILO_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_i |=> ($stable(lo_i) && $stable(hi_i))); // R10
endmodule

bind sdiv_hilo sdiv_hilo_chk #(.W(W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_i  (cmd_go),
  .busy_i   (core_busy),
  .done_i   (core_done),
  .rd_req_i (rd_req_i),
  .stall_i  (stall_o),
  .lo_i     (lo_q),
  .hi_i     (hi_q)
);

// File: tb/sdiv_hilo_test.sv
module sdiv_hilo_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        issue_i = 1'b0;
  logic [15:0] instr_i = '0;
  logic [31:0] op_a_i = '0, op_b_i = '0;
  logic [2:0]  src_a_idx_o, src_b_idx_o;
  logic        rd_req_i = 1'b0, rd_sel_i = 1'b0;
  logic [31:0] rd_data_o;
  logic        stall_o;

  int n_chk = 0, n_fail = 0;

  always #5ns clk_i = ~clk_i;

  sdiv_hilo uut (.*);

  function automatic logic [15:0] mk_instr(input logic [2:0] rx, input logic [2:0] ry);
    return {5'b11101, rx, ry, 5'b11010};
  endfunction

  function automatic int sig_of(input logic [31:0] x);
    int s = 0;
    for (int i = 0; i < 32; i++) if (x[i]) s = i + 1;
    return s;
  endfunction

  function automatic int ref_lat(input logic [31:0] a, input logic [31:0] b);
    logic [31:0] am, bm;
    int d;
    if (b == 0) return 2;
    am = a[31] ? -a : a;
    bm = b[31] ? -b : b;
    d = sig_of(am) - sig_of(bm) + 1;
    return (d > 0 ? d : 0) + 2;
  endfunction

  task automatic ref_div(input logic signed [31:0] a, input logic signed [31:0] b,
                         output logic [31:0] q, output logic [31:0] r);
    if (b == 0) begin q = '1; r = a; end
    else if (a == 32'sh80000000 && b == -32'sd1) begin q = a; r = 0; end
    else begin q = a / b; r = a % b; end
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [31:0] a, input logic [31:0] b);
    @(negedge clk_i);
    issue_i = 1'b1; instr_i = mk_instr(3'd1, 3'd2); op_a_i = a; op_b_i = b;
    @(negedge clk_i);
    issue_i = 1'b0;
  endtask

  task automatic wait_done(output int cyc);
    cyc = 0;
    rd_req_i = 1'b1;
    #1;
    while (stall_o && cyc < 100) begin
      cyc++;
      @(negedge clk_i);
      #1;
    end
  endtask

  task automatic read_reg(input logic sel, output logic [31:0] d);
    rd_sel_i = sel;
    #1;
    d = rd_data_o;
  endtask

  task automatic run_div(input logic [31:0] a, input logic [31:0] b, input string tag);
    logic [31:0] eq, er, d;
    int cyc;
    ref_div(a, b, eq, er);
    issue(a, b);
    wait_done(cyc);
    chk({tag, " R9 latency"}, 32'(cyc), 32'(ref_lat(a, b)));
    read_reg(1'b0, d); chk({tag, " LO"}, d, eq);
    read_reg(1'b1, d); chk({tag, " HI"}, d, er);
    rd_req_i = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd_req_i = 1'b1;
    read_reg(1'b0, d); chk("R10 reset LO", d, 0);
    read_reg(1'b1, d); chk("R10 reset HI", d, 0);
    chk("R7 idle no stall", 32'(stall_o), 0);
    rd_req_i = 1'b0;
  endtask

  task automatic t_signs();
    run_div(32'd7, 32'd3, "R3 R4 pos/pos");
    run_div(-32'd7, 32'd3, "R3 R4 neg/pos");
    run_div(32'd7, -32'd3, "R3 R4 pos/neg");
    run_div(-32'd7, -32'd3, "R3 R4 neg/neg");
    run_div(32'd100000, 32'd7, "R3 R4 wide");
    run_div(-32'd123456789, 32'd1000, "R3 R4 big");
  endtask

  task automatic t_latency();
    run_div(32'h7fffffff, 32'd1, "R9 long");
    run_div(32'd3, 32'd7, "R9 small dividend");
    run_div(32'd0, 32'd5, "R9 zero dividend");
  endtask

  task automatic t_zero();
    run_div(32'd1234, 32'd0, "R5 zero div pos");
    run_div(-32'd5, 32'd0, "R5 zero div neg");
  endtask

  task automatic t_overflow();
    run_div(32'h80000000, 32'hffffffff, "R6 overflow");
  endtask

  task automatic t_decode();
    logic [31:0] d, prev;
    @(negedge clk_i);
    instr_i = mk_instr(3'd5, 3'd2);
    #1;
    chk("R2 idx a", 32'(src_a_idx_o), 5);
    chk("R2 idx b", 32'(src_b_idx_o), 2);
    rd_req_i = 1'b1;
    read_reg(1'b0, prev);
    // wrong major field with valid asserted
    issue_i = 1'b1; instr_i = 16'b11100_001_010_11010; op_a_i = 32'd9; op_b_i = 32'd2;
    @(negedge clk_i); issue_i = 1'b0; #1;
    chk("R1 bad opcode no stall", 32'(stall_o), 0);
    read_reg(1'b0, d); chk("R1 bad opcode LO", d, prev);
    // right word with valid low
    instr_i = mk_instr(3'd1, 3'd2);
    @(negedge clk_i); #1;
    chk("R1 no issue no stall", 32'(stall_o), 0);
    read_reg(1'b0, d); chk("R1 no issue LO", d, prev);
    rd_req_i = 1'b0;
  endtask

  task automatic t_same_cycle();
    logic [31:0] prev, d;
    int cyc;
    rd_req_i = 1'b1;
    read_reg(1'b0, prev);
    @(negedge clk_i);
    issue_i = 1'b1; instr_i = mk_instr(3'd3, 3'd4); op_a_i = 32'd50; op_b_i = 32'd6;
    rd_sel_i = 1'b0;
    #1;
    chk("R8 same cycle no stall", 32'(stall_o), 0);
    chk("R8 same cycle old LO", rd_data_o, prev);
    @(negedge clk_i);
    issue_i = 1'b0;
    wait_done(cyc);
    chk("R8 follow-up R9 latency", 32'(cyc), 32'(ref_lat(32'd50, 32'd6)));
    read_reg(1'b0, d); chk("R8 follow-up LO", d, 32'd8);
    rd_req_i = 1'b0;
  endtask

  task automatic t_abort();
    logic [31:0] prev, d, eq, er;
    int cyc;
    read_reg(1'b0, prev);
    issue(32'd1000, 32'd3);
    repeat (3) begin
      #1; chk("R10 LO held in flight", rd_data_o, prev);
      @(negedge clk_i);
    end
    issue(-32'd50, 32'd7);
    wait_done(cyc);
    ref_div(-32'd50, 32'd7, eq, er);
    chk("R10 restart latency", 32'(cyc), 32'(ref_lat(-32'd50, 32'd7)));
    read_reg(1'b0, d); chk("R10 restart LO", d, eq);
    read_reg(1'b1, d); chk("R10 restart HI", d, er);
    rd_req_i = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_signs();
    t_latency();
    t_zero();
    t_overflow();
    t_decode();
    t_same_cycle();
    t_abort();
    repeat (2) @(negedge clk_i);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule